// File: doc/BRIEF.md
# Interleaved Four-Bank Block Refill Controller

This block answers cache-block refill requests that arrive over a one-word processor bus. Four independent memory banks sit behind it. Consecutive word addresses fall in consecutive banks, so word `a` lives in bank `a mod 4` at row `a / 4`. When a block request is accepted, the controller hands the same row to all four banks in one cycle and lets their cycle times run side by side. It then streams the four words back on the bus in four consecutive cycles. A whole refill therefore costs one bank cycle plus one transfer for each extra word. A memory with a single bank would pay the full cycle for every word.

Each bank is modelled as a synchronous array with a busy timer. The read data settles after the access latency, and the bank takes no new access until its cycle time has run out. The controller also measures every refill and reports the miss penalty in clock cycles. The request that starts the refill counts as cycle 1, and the cycle that carries the last word is counted as well.

The sequencer has three states. `S_IDLE` accepts requests. It moves to `S_BANKWAIT` on an aligned request and stays in `S_IDLE` on a misaligned one, raising the error flag. `S_BANKWAIT` waits for the bank cycle and moves to `S_STREAM` in the last busy cycle of the banks. `S_STREAM` sends one word per cycle and returns to `S_IDLE` with the last word.

Top module: `ilv_refill_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid`, `rsp_last`, `req_err` and `miss_penalty` are all 0.
- R2: Word address `a` is held in bank `a mod 4` at row `a >> 2`. Its stored value is the 32-bit word `{~a[15:0], a[15:0]}`, with `a` zero-extended to 16 bits.
- R3: An accepted request starts all banks in the same cycle. No bank is restarted while its 10-cycle cycle time is still running.
- R4: Counting the request cycle as cycle 1, the first word is valid in cycle 12. The four words occupy cycles 12 to 15 with no gap, and `rsp_valid` stays 0 in cycles 2 to 11.
- R5: The words come back in ascending address order, base+0 to base+3. `rsp_last` is 1 only on the fourth word.
- R6: After a refill, `miss_penalty` reads 15, which is 1+10+1+3. It does not read the 48 cycles of a single-bank refill.
- R7: `req_ready` is 0 from the cycle after acceptance up to and including cycle 15. It is 1 again in cycle 16. A `req_valid` raised while `req_ready` is 0 is ignored: it produces no stream and no error.
- R8: A request whose base has nonzero low two bits raises `req_err` for exactly one cycle, the cycle after the request. No bank is started, no word is returned, and `req_ready` stays 1.
- R9: The highest aligned block of the address space (base 1020 with 10-bit addresses) returns its four words correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Block request present |
| req_base | input | ADDR_W (10) | Word address of the block base |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_err | output | 1 | One-cycle pulse: a misaligned request was refused |
| rsp_valid | output | 1 | Returned word valid |
| rsp_last | output | 1 | Marks the fourth word of a block |
| rsp_data | output | DATA_W (32) | Returned word |
| miss_penalty | output | PEN_W (8) | Cycles taken by the most recent refill |

## Verification
The bench uses the default parameters: 10-bit word addresses, 4 banks, an access latency of 4 and a bank cycle of 10. With these values the 15-versus-48 comparison is reachable, and the edge of the address space is only 1020 words away, so the top block can be exercised directly. Keeping the access latency well below the cycle time also shows that the stream waits for the full bank cycle and not just for the data. The small bank depth keeps the computed memory contents cheap while still spanning all four bank indices.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_BANKWAIT = 2'd1,
        S_STREAM   = 2'd2
    } seq_state_t;

    // Deterministic contents of word address a.
    function automatic logic [31:0] ilv_fill(input logic [31:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int BANK_IDX = 0,
    parameter int NBANK    = 4,
    parameter int ROW_W    = 8,
    parameter int DATA_W   = 32,
    parameter int ACC_LAT  = 4,
    parameter int CYC_T    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ROW_W-1:0]  row,
    output logic              busy,
    output logic              last_busy,
    output logic [DATA_W-1:0] rdata
);
    import ilv_pkg::*;

    localparam int ROWS   = 1 << ROW_W;
    localparam int CNT_W  = $clog2(CYC_T + 1);
    localparam int CAP_AT = CYC_T - ACC_LAT + 1;

    logic [DATA_W-1:0] mem [ROWS];
    logic [CNT_W-1:0]  cnt_q;
    logic [ROW_W-1:0]  row_q;

    initial begin
        for (int r = 0; r < ROWS; r++) begin
            mem[r] = DATA_W'(ilv_fill(32'(r * NBANK + BANK_IDX)));
        end
    end

    assign busy      = (cnt_q != '0);
    assign last_busy = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            row_q <= '0;
            rdata <= '0;
        end else begin
            if (go) begin
                cnt_q <= CNT_W'(CYC_T);
                row_q <= row;
            end else if (busy) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (busy && cnt_q == CNT_W'(CAP_AT)) begin
                rdata <= mem[row_q];
            end
        end
    end

    // R3: a bank is never restarted inside its cycle time
    assert_no_reissue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);

endmodule

// File: rtl/ilv_seq.sv
module ilv_seq #(
    parameter int NBANK  = 4,
    parameter int ADDR_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_base,
    input  logic                     banks_last,
    output logic                     req_ready,
    output logic                     req_err,
    output logic                     bank_go,
    output logic                     in_flight,
    output logic                     out_valid,
    output logic                     out_last,
    output logic [$clog2(NBANK)-1:0] beat
);
    import ilv_pkg::*;

    localparam int BSEL_W = $clog2(NBANK);
    localparam logic [BSEL_W-1:0] LAST_BEAT = BSEL_W'(NBANK - 1);

    seq_state_t        state_q, state_d;
    logic [BSEL_W-1:0] beat_q;
    logic              err_d;
    logic              aligned;

    assign aligned   = (req_base[BSEL_W-1:0] == '0);
    assign beat      = beat_q;
    assign in_flight = (state_q != S_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            beat_q  <= '0;
            req_err <= 1'b0;
        end else begin
            state_q <= state_d;
            req_err <= err_d;
            if (state_q == S_STREAM) begin
                beat_q <= out_last ? '0 : beat_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        bank_go   = 1'b0;
        err_d     = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    if (aligned) begin
                        bank_go = 1'b1;
                        state_d = S_BANKWAIT;
                    end else begin
                        err_d = 1'b1;
                    end
                end
            end
            S_BANKWAIT: begin
                if (banks_last) state_d = S_STREAM;
            end
            S_STREAM: begin
                out_valid = 1'b1;
                out_last  = (beat_q == LAST_BEAT);
                if (out_last) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // R7: ready drops once a request is taken
    assert_ready_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && aligned) |=> !req_ready);

    // R8: a refused request leaves the controller ready
    assert_err_no_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !aligned) |=> (req_ready && req_err));

    // R5: last flag only with a valid word
    assert_last_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

endmodule

// File: rtl/ilv_penalty.sv
module ilv_penalty #(
    parameter int PEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic             stop,
    output logic [PEN_W-1:0] penalty
);
    // The cycle after acceptance is cycle 2 of the refill.
    localparam logic [PEN_W-1:0] FIRST_AFTER = PEN_W'(2);

    logic [PEN_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            penalty <= '0;
        end else begin
            if (start) begin
                cnt_q <= FIRST_AFTER;
            end else if (run) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (stop) begin
                penalty <= cnt_q;
            end
        end
    end

    // R6: the counter only advances while a refill is in flight
    assert_count_in_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> run);

endmodule

// File: rtl/ilv_refill_ctrl.sv
module ilv_refill_ctrl #(
    parameter int NBANK   = 4,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32,
    parameter int ACC_LAT = 4,
    parameter int CYC_T   = 10,
    parameter int PEN_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_base,
    output logic              req_ready,
    output logic              req_err,
    output logic              rsp_valid,
    output logic              rsp_last,
    output logic [DATA_W-1:0] rsp_data,
    output logic [PEN_W-1:0]  miss_penalty
);
    localparam int BSEL_W = $clog2(NBANK);
    localparam int ROW_W  = ADDR_W - BSEL_W;

    logic [NBANK-1:0]  bank_busy;
    logic [NBANK-1:0]  bank_last;
    logic [DATA_W-1:0] bank_rdata [NBANK];
    logic              bank_go;
    logic              in_flight;
    logic [BSEL_W-1:0] beat;
    logic [ROW_W-1:0]  row;

    assign row = req_base[ADDR_W-1:BSEL_W];

    ilv_seq #(
        .NBANK (NBANK),
        .ADDR_W(ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_base  (req_base),
        .banks_last(&bank_last),
        .req_ready (req_ready),
        .req_err   (req_err),
        .bank_go   (bank_go),
        .in_flight (in_flight),
        .out_valid (rsp_valid),
        .out_last  (rsp_last),
        .beat      (beat)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        ilv_bank #(
            .BANK_IDX(b),
            .NBANK   (NBANK),
            .ROW_W   (ROW_W),
            .DATA_W  (DATA_W),
            .ACC_LAT (ACC_LAT),
            .CYC_T   (CYC_T)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .go       (bank_go),
            .row      (row),
            .busy     (bank_busy[b]),
            .last_busy(bank_last[b]),
            .rdata    (bank_rdata[b])
        );
    end

    assign rsp_data = rsp_valid ? bank_rdata[beat] : '0;

    ilv_penalty #(
        .PEN_W(PEN_W)
    ) u_pen (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (bank_go),
        .run    (in_flight),
        .stop   (rsp_last),
        .penalty(miss_penalty)
    );

    // R4: words are only streamed once every bank cycle has ended
    assert_stream_after_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (bank_busy == '0));

endmodule

// File: tb/tb_ilv_refill_ctrl.sv
`timescale 1ns/100ps
module tb_ilv_refill_ctrl;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int PEN_W  = 8;
    localparam int NVEC   = 8;

    localparam logic [ADDR_W-1:0] VEC_BASE [NVEC] = '{
        10'd0, 10'd4, 10'd8, 10'd12, 10'd340, 10'd680, 10'd1016, 10'd1020
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_base = '0;
    logic              req_ready, req_err, rsp_valid, rsp_last;
    logic [DATA_W-1:0] rsp_data;
    logic [PEN_W-1:0]  miss_penalty;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ilv_refill_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_base    (req_base),
        .req_ready   (req_ready),
        .req_err     (req_err),
        .rsp_valid   (rsp_valid),
        .rsp_last    (rsp_last),
        .rsp_data    (rsp_data),
        .miss_penalty(miss_penalty)
    );

    function automatic logic [31:0] expect_word(input logic [ADDR_W-1:0] a);
        logic [15:0] a16;
        a16 = 16'(a);
        return {~a16, a16};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Issues one aligned block and checks its whole timeline.
    // The request cycle is cycle 1.
    task automatic run_block(input logic [ADDR_W-1:0] base, input bit poke_busy);
        bit quiet;
        req_valid = 1'b1;
        req_base  = base;
        step();                                 // now cycle 2
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R7 ready low after accept", 64'(req_ready), 64'd0);
        quiet = 1'b1;
        for (int c = 2; c <= 11; c++) begin
            if (rsp_valid) quiet = 1'b0;
            if (!req_ready == 1'b0) quiet = 1'b0;
            if (poke_busy && c == 3) begin
                req_valid = 1'b1;               // R7: ignored while busy
                req_base  = base ^ 10'd8;
            end
            if (poke_busy && c == 5) req_valid = 1'b0;
            if (c < 11) step();
        end
        chk(quiet, "R4 R7 no word and not ready in cycles 2..11", 64'(quiet), 64'd1);
        for (int k = 0; k < 4; k++) begin
            step();                             // cycles 12..15
            chk(rsp_valid == 1'b1, "R4 word valid in cycles 12..15", 64'(rsp_valid), 64'd1);
            chk(rsp_data == expect_word(base + ADDR_W'(k)), "R2 R5 R9 word data/order",
                64'(rsp_data), 64'(expect_word(base + ADDR_W'(k))));
            chk(rsp_last == (k == 3), "R5 last flag on fourth word only",
                64'(rsp_last), 64'(k == 3));
            chk(req_ready == 1'b0, "R7 ready low during stream", 64'(req_ready), 64'd0);
        end
        step();                                 // cycle 16
        chk(miss_penalty == PEN_W'(15), "R6 penalty is 15 not 48",
            64'(miss_penalty), 64'd15);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R7 ready back in cycle 16",
            64'({req_ready, rsp_valid}), 64'b10);
        if (poke_busy) begin
            step();
            step();
            chk(rsp_valid == 1'b0 && req_err == 1'b0, "R7 busy-time request ignored",
                64'({rsp_valid, req_err}), 64'd0);
        end
    endtask

    initial begin : watchdog
        wait (cyc > 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R4 run did not complete actual=%0d expected<20000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        step();
        step();
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0 && rsp_last == 1'b0 && req_err == 1'b0,
            "R1 outputs quiet in reset", 64'({rsp_valid, rsp_last, req_err}), 64'd0);
        chk(miss_penalty == '0, "R1 penalty zero in reset", 64'(miss_penalty), 64'd0);
        rst_n = 1'b1;
        step();
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 idle after reset release",
            64'({req_ready, rsp_valid}), 64'b10);

        // Table walk: R2 R3 R4 R5 R6 R7, last entries cover R9
        for (int v = 0; v < NVEC; v++) begin
            run_block(VEC_BASE[v], 1'b0);
        end

        // R3 / R7: back-to-back request right when ready returns
        run_block(10'd100, 1'b0);
        run_block(10'd104, 1'b0);

        // R7: requests while busy are ignored
        run_block(10'd200, 1'b1);

        // R8: misaligned base
        for (int m = 1; m < 4; m++) begin
            bit quiet;
            req_valid = 1'b1;
            req_base  = 10'd40 + ADDR_W'(m);
            step();
            req_valid = 1'b0;
            chk(req_err == 1'b1 && req_ready == 1'b1, "R8 error pulse, still ready",
                64'({req_err, req_ready}), 64'b11);
            step();
            chk(req_err == 1'b0, "R8 error lasts one cycle", 64'(req_err), 64'd0);
            quiet = 1'b1;
            for (int c = 0; c < 16; c++) begin
                if (rsp_valid || !req_ready) quiet = 1'b0;
                step();
            end
            chk(quiet, "R8 misaligned request issues nothing", 64'(quiet), 64'd1);
        end

        // R9: top block once more after the error cases
        run_block(10'd1020, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule